// File: doc/BRIEF.md
# Wide Transfer Residue Combiner

This block turns a byte-serial receive or send stream into 16-bit words for a wide data path during block moves. Bytes are paired in arrival order. When a receive transfer whose instruction carries the opcode qualifier ends after an odd number of bytes, the final byte is not emitted. It is parked in a residue register instead. The next qualified receive transfer pairs the parked byte with its own first byte, so the wide path only ever sees complete words across instruction boundaries.

The block also enforces a halt policy. Initiator attention, or a byte flagged with a parity error, stops the transfer and raises an interrupt. This happens unless the disable-halt control is set. In that case both events are only recorded and the transfer runs to completion. A halted transfer keeps its remaining byte count and resumes on a restart pulse.

Top module: `wide_residue_combiner`

## Requirements
- R1: Within a transfer, bytes are paired in arrival order: the first byte of each pair goes to wordData[7:0] and the second to wordData[15:8]. wordValid is high for exactly the one cycle after the second byte is accepted.
- R2: A transfer started with xferReceive=1 and xferOpcodeBit=1 that ends on an odd byte does not emit its last byte. That byte is stored, and residueHeld reads 1 from the cycle after that byte.
- R3: A transfer started with xferReceive=1 and xferOpcodeBit=1 while residueHeld=1 emits the stored byte in wordData[7:0] and its own first byte in wordData[15:8]. residueHeld falls in the same cycle that word is emitted.
- R4: A transfer with xferReceive=0 or xferOpcodeBit=0 emits an odd last byte as {8'h00, byte}. Such a transfer neither merges nor changes the stored residue, and residueHeld keeps its value.
- R5: With disableHalt=0, attention high during a transfer, or a byte presented with parityErr=1, stops the transfer. A flagged byte is not consumed. halted and intFlag read 1 from the next cycle, and the matching atnSeen or parSeen bit is set.
- R6: While halted, wordValid stays 0 and the remaining count is frozen. A restart pulse clears halted and intFlag, and the transfer resumes with the count it had.
- R7: With disableHalt=1, attention and parity errors set atnSeen/parSeen but neither halt the transfer nor set intFlag. Bytes are consumed normally.
- R8: atnSeen and parSeen are cleared when a transfer starts.
- R9: xferDone is high for exactly the one cycle after the last byte of a transfer is accepted.
- R10: xferStart is ignored when xferCount is 0 or when a transfer is already in progress.
- R11: After reset, wordValid, halted, intFlag, residueHeld and xferDone are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xferStart | input | 1 | Pulse that starts a transfer |
| xferCount | input | CNT_W | Byte count of the transfer being started |
| xferReceive | input | 1 | 1 = receive transfer, 0 = send |
| xferOpcodeBit | input | 1 | Instruction qualifier that enables residue handling |
| byteValid | input | 1 | byteData carries a byte this cycle |
| byteData | input | LANE_W | Incoming byte |
| parityErr | input | 1 | Parity error flag for the current byte |
| attention | input | 1 | Initiator attention level |
| disableHalt | input | 1 | 1 = record attention and parity errors without halting |
| restart | input | 1 | Pulse that resumes a halted transfer |
| wordValid | output | 1 | wordData holds a word this cycle |
| wordData | output | 2*LANE_W | Assembled word |
| xferDone | output | 1 | Transfer completed |
| residueHeld | output | 1 | A residue byte is parked |
| halted | output | 1 | Transfer is halted |
| intFlag | output | 1 | Halt interrupt |
| atnSeen | output | 1 | Attention seen in this transfer |
| parSeen | output | 1 | Parity error seen in this transfer |

## Verification
The bench chains transfers so that a residue is parked, carried through a send transfer and through a receive with the qualifier clear, and only then merged. A design that merged or overwrote the residue in the wrong transfer would emit the wrong lane contents or a zero-padded word. The bench checks that the flagged byte is presented again after restart and completes the pair. A design that consumed the flagged byte, or lost its count while halted, would end the transfer early or late. The bench also issues starts with a zero count and starts during a busy transfer. A design that accepted either would emit a word where none is due, or split a pair across the wrong transfer.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
  typedef struct packed {
    logic accept;   // consume byteData this cycle
    logic last;     // the consumed byte ends the transfer
    logic merge;    // preload the residue into the low lane
    logic capture;  // odd trailing byte goes to residue
  } wrc_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HALT = 2'd2
  } wrc_state_e;
endpackage

// File: rtl/wrc_control.sv
module wrc_control
  import wrc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xferStart,
  input  logic [CNT_W-1:0] xferCount,
  input  logic             xferReceive,
  input  logic             xferOpcodeBit,
  input  logic             byteValid,
  input  logic             parityErr,
  input  logic             attention,
  input  logic             disableHalt,
  input  logic             restart,
  output wrc_strobe_t      stb,
  output logic             xferDone,
  output logic             halted,
  output logic             intFlag,
  output logic             atnSeen,
  output logic             parSeen
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  wrc_state_e       state;
  logic [CNT_W-1:0] remain;
  logic             capEn;
  logic             startOk;
  logic             haltReq;
  logic             parHit;

  assign startOk = (state == ST_IDLE) && xferStart && (xferCount != '0);
  assign parHit  = byteValid && parityErr;
  assign haltReq = (state == ST_RUN) && !disableHalt && (attention || parHit);

  always_comb begin
    stb         = '0;
    stb.capture = capEn;
    stb.merge   = startOk && xferReceive && xferOpcodeBit;
    stb.accept  = (state == ST_RUN) && byteValid && !haltReq;
    stb.last    = stb.accept && (remain == ONE);
  end

  assign halted = (state == ST_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      remain   <= '0;
      capEn    <= 1'b0;
      xferDone <= 1'b0;
      intFlag  <= 1'b0;
      atnSeen  <= 1'b0;
      parSeen  <= 1'b0;
    end else begin
      xferDone <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (startOk) begin
            remain  <= xferCount;
            capEn   <= xferReceive && xferOpcodeBit;
            atnSeen <= 1'b0;
            parSeen <= 1'b0;
            state   <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (attention) atnSeen <= 1'b1;
          if (parHit)    parSeen <= 1'b1;
          if (haltReq) begin
            intFlag <= 1'b1;
            state   <= ST_HALT;
          end else if (stb.accept) begin
            remain <= remain - ONE;
            if (stb.last) begin
              xferDone <= 1'b1;
              state    <= ST_IDLE;
            end
          end
        end
        ST_HALT: begin
          if (restart) begin
            intFlag <= 1'b0;
            state   <= ST_RUN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wrc_datapath.sv
module wrc_datapath
  import wrc_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  wrc_strobe_t         stb,
  input  logic [LANE_W-1:0]   byteData,
  output logic                wordValid,
  output logic [2*LANE_W-1:0] wordData,
  output logic                residueHeld
);
  logic [LANE_W-1:0] lowByte;
  logic              lowFull;
  logic              lowFromRes;
  logic [LANE_W-1:0] resByte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowByte     <= '0;
      lowFull     <= 1'b0;
      lowFromRes  <= 1'b0;
      resByte     <= '0;
      residueHeld <= 1'b0;
      wordValid   <= 1'b0;
      wordData    <= '0;
    end else begin
      wordValid <= 1'b0;
      if (stb.merge && residueHeld) begin
        lowByte    <= resByte;
        lowFull    <= 1'b1;
        lowFromRes <= 1'b1;
      end else if (stb.accept) begin
        if (lowFull) begin
          wordData   <= {byteData, lowByte};
          wordValid  <= 1'b1;
          lowFull    <= 1'b0;
          lowFromRes <= 1'b0;
          if (lowFromRes) residueHeld <= 1'b0;
        end else if (stb.last) begin
          if (stb.capture) begin
            resByte     <= byteData;
            residueHeld <= 1'b1;
          end else begin
            wordData  <= {{LANE_W{1'b0}}, byteData};
            wordValid <= 1'b1;
          end
        end else begin
          lowByte <= byteData;
          lowFull <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wide_residue_combiner.sv
module wide_residue_combiner
  import wrc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                xferStart,
  input  logic [CNT_W-1:0]    xferCount,
  input  logic                xferReceive,
  input  logic                xferOpcodeBit,
  input  logic                byteValid,
  input  logic [LANE_W-1:0]   byteData,
  input  logic                parityErr,
  input  logic                attention,
  input  logic                disableHalt,
  input  logic                restart,
  output logic                wordValid,
  output logic [2*LANE_W-1:0] wordData,
  output logic                xferDone,
  output logic                residueHeld,
  output logic                halted,
  output logic                intFlag,
  output logic                atnSeen,
  output logic                parSeen
);
  wrc_strobe_t stb;

  wrc_control #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .xferStart(xferStart), .xferCount(xferCount),
    .xferReceive(xferReceive), .xferOpcodeBit(xferOpcodeBit),
    .byteValid(byteValid), .parityErr(parityErr),
    .attention(attention), .disableHalt(disableHalt), .restart(restart),
    .stb(stb), .xferDone(xferDone), .halted(halted), .intFlag(intFlag),
    .atnSeen(atnSeen), .parSeen(parSeen)
  );

  wrc_datapath #(.LANE_W(LANE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .byteData(byteData),
    .wordValid(wordValid), .wordData(wordData), .residueHeld(residueHeld)
  );
endmodule

// File: rtl/wrc_checker.sv
module wrc_checker (
  input logic clk,
  input logic rst_n,
  input logic restart,
  input logic wordValid,
  input logic xferDone,
  input logic residueHeld,
  input logic halted,
  input logic intFlag
);
  // R6
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !wordValid);

  // R6
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !restart) |=> halted);

  // R5
  halt_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> intFlag);

  // R3
  res_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(residueHeld) |-> wordValid);

  // R2
  res_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(residueHeld) |-> (xferDone && !wordValid));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xferDone |=> !xferDone);
endmodule

bind wide_residue_combiner wrc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .restart(restart), .wordValid(wordValid),
  .xferDone(xferDone), .residueHeld(residueHeld), .halted(halted),
  .intFlag(intFlag)
);

// File: tb/wide_residue_combiner_bench.sv
module wide_residue_combiner_bench;
  localparam int CNT_W  = 16;
  localparam int LANE_W = 8;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                xferStart = 1'b0;
  logic [CNT_W-1:0]    xferCount = '0;
  logic                xferReceive = 1'b0;
  logic                xferOpcodeBit = 1'b0;
  logic                byteValid = 1'b0;
  logic [LANE_W-1:0]   byteData = '0;
  logic                parityErr = 1'b0;
  logic                attention = 1'b0;
  logic                disableHalt = 1'b0;
  logic                restart = 1'b0;
  logic                wordValid;
  logic [2*LANE_W-1:0] wordData;
  logic                xferDone;
  logic                residueHeld;
  logic                halted;
  logic                intFlag;
  logic                atnSeen;
  logic                parSeen;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;

  wide_residue_combiner #(.CNT_W(CNT_W), .LANE_W(LANE_W)) u_wide_residue_combiner (
    .clk(clk), .rst_n(rst_n), .xferStart(xferStart), .xferCount(xferCount),
    .xferReceive(xferReceive), .xferOpcodeBit(xferOpcodeBit),
    .byteValid(byteValid), .byteData(byteData), .parityErr(parityErr),
    .attention(attention), .disableHalt(disableHalt), .restart(restart),
    .wordValid(wordValid), .wordData(wordData), .xferDone(xferDone),
    .residueHeld(residueHeld), .halted(halted), .intFlag(intFlag),
    .atnSeen(atnSeen), .parSeen(parSeen)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic startXfer(input int cnt, input logic rx, input logic opc);
    @(negedge clk);
    xferStart = 1'b1; xferCount = CNT_W'(cnt);
    xferReceive = rx; xferOpcodeBit = opc;
    @(negedge clk);
    xferStart = 1'b0;
  endtask

  // Outputs caused by the byte are valid when this task returns.
  task automatic putByte(input logic [7:0] b, input logic pe);
    @(negedge clk);
    byteValid = 1'b1; byteData = b; parityErr = pe;
    @(negedge clk);
    byteValid = 1'b0; parityErr = 1'b0;
  endtask

  task automatic testReset();
    chk("R11", "wordValid", 32'(wordValid), 0);
    chk("R11", "halted", 32'(halted), 0);
    chk("R11", "intFlag", 32'(intFlag), 0);
    chk("R11", "residueHeld", 32'(residueHeld), 0);
    chk("R11", "xferDone", 32'(xferDone), 0);
  endtask

  task automatic testEvenPairs();
    startXfer(4, 1'b1, 1'b1);
    putByte(8'hA1, 1'b0);
    chk("R1", "no word after first byte", 32'(wordValid), 0);
    putByte(8'hB2, 1'b0);
    chk("R1", "word valid", 32'(wordValid), 1);
    chk("R1", "word lanes", 32'(wordData), 32'hB2A1);
    @(negedge clk);
    chk("R1", "valid single cycle", 32'(wordValid), 0);
    putByte(8'hC3, 1'b0);
    putByte(8'hD4, 1'b0);
    chk("R1", "second word", 32'(wordData), 32'hD4C3);
    chk("R9", "done with last", 32'(xferDone), 1);
    @(negedge clk);
    chk("R9", "done one cycle", 32'(xferDone), 0);
    chk("R2", "even end leaves no residue", 32'(residueHeld), 0);
  endtask

  task automatic testResidueChain();
    startXfer(3, 1'b1, 1'b1);
    putByte(8'h11, 1'b0);
    putByte(8'h22, 1'b0);
    chk("R1", "word", 32'(wordData), 32'h2211);
    putByte(8'h33, 1'b0);
    chk("R2", "odd byte not emitted", 32'(wordValid), 0);
    chk("R2", "residue held", 32'(residueHeld), 1);
    startXfer(2, 1'b1, 1'b1);
    putByte(8'h44, 1'b0);
    chk("R3", "merged valid", 32'(wordValid), 1);
    chk("R3", "merged lanes", 32'(wordData), 32'h4433);
    chk("R3", "residue cleared", 32'(residueHeld), 0);
    putByte(8'h55, 1'b0);
    chk("R2", "new residue held", 32'(residueHeld), 1);
    chk("R2", "no word", 32'(wordValid), 0);
    // send transfer: no merge, pad, residue untouched
    startXfer(1, 1'b0, 1'b1);
    putByte(8'h66, 1'b0);
    chk("R4", "send odd padded", 32'(wordData), 32'h0066);
    chk("R4", "send odd valid", 32'(wordValid), 1);
    chk("R4", "residue kept on send", 32'(residueHeld), 1);
    // receive with qualifier clear
    startXfer(3, 1'b1, 1'b0);
    putByte(8'h77, 1'b0);
    chk("R4", "no merge without qualifier", 32'(wordValid), 0);
    putByte(8'h88, 1'b0);
    chk("R4", "plain pair", 32'(wordData), 32'h8877);
    putByte(8'h99, 1'b0);
    chk("R4", "unqualified odd padded", 32'(wordData), 32'h0099);
    chk("R4", "residue kept", 32'(residueHeld), 1);
    startXfer(1, 1'b1, 1'b1);
    putByte(8'hAA, 1'b0);
    chk("R3", "late merge lanes", 32'(wordData), 32'hAA55);
    chk("R3", "late merge clears", 32'(residueHeld), 0);
  endtask

  task automatic testParityHalt();
    disableHalt = 1'b0;
    startXfer(2, 1'b1, 1'b0);
    putByte(8'h01, 1'b0);
    putByte(8'h02, 1'b1);
    chk("R5", "halted on parity", 32'(halted), 1);
    chk("R5", "interrupt", 32'(intFlag), 1);
    chk("R5", "parSeen", 32'(parSeen), 1);
    chk("R5", "flagged byte dropped", 32'(wordValid), 0);
    putByte(8'hEE, 1'b0);
    chk("R6", "no output while halted", 32'(wordValid), 0);
    chk("R6", "still halted", 32'(halted), 1);
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    chk("R6", "restart clears halt", 32'(halted), 0);
    chk("R6", "restart clears irq", 32'(intFlag), 0);
    putByte(8'h02, 1'b0);
    chk("R6", "resumed word", 32'(wordData), 32'h0201);
    chk("R6", "count frozen then done", 32'(xferDone), 1);
  endtask

  task automatic testAtnHalt();
    startXfer(2, 1'b1, 1'b0);
    chk("R8", "parSeen cleared at start", 32'(parSeen), 0);
    @(negedge clk); attention = 1'b1;
    @(negedge clk); attention = 1'b0;
    chk("R5", "halted on attention", 32'(halted), 1);
    chk("R5", "atnSeen", 32'(atnSeen), 1);
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    putByte(8'h12, 1'b0);
    putByte(8'h34, 1'b0);
    chk("R6", "word after atn restart", 32'(wordData), 32'h3412);
  endtask

  task automatic testDisabled();
    disableHalt = 1'b1;
    startXfer(2, 1'b1, 1'b0);
    chk("R8", "atnSeen cleared at start", 32'(atnSeen), 0);
    attention = 1'b1;
    putByte(8'h5A, 1'b1);
    chk("R7", "no halt", 32'(halted), 0);
    putByte(8'hA5, 1'b0);
    attention = 1'b0;
    chk("R7", "word completes", 32'(wordData), 32'hA55A);
    chk("R7", "done", 32'(xferDone), 1);
    chk("R7", "no irq", 32'(intFlag), 0);
    chk("R7", "atnSeen", 32'(atnSeen), 1);
    chk("R7", "parSeen", 32'(parSeen), 1);
    disableHalt = 1'b0;
  endtask

  task automatic testIgnoredStarts();
    startXfer(0, 1'b1, 1'b1);
    putByte(8'h01, 1'b0);
    putByte(8'h02, 1'b0);
    chk("R10", "zero count ignored", 32'(wordValid), 0);
    chk("R10", "no done", 32'(xferDone), 0);
    startXfer(2, 1'b1, 1'b0);
    putByte(8'h21, 1'b0);
    startXfer(1, 1'b0, 1'b0);
    putByte(8'h43, 1'b0);
    chk("R10", "busy start ignored", 32'(wordData), 32'h4321);
    chk("R10", "old transfer done", 32'(xferDone), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testEvenPairs();
    testResidueChain();
    testParityHalt();
    testAtnHalt();
    testDisabled();
    testIgnoredStarts();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule